// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This unit decides the result of a two-operand binary32 operation when at least one operand is a NaN. Each operand is sorted into one of three classes: ordinary number, quiet NaN or signaling NaN. A run-time policy then picks one of the two operands. If the picked operand is signaling, the unit quiets it. It also raises the invalid-operation indication whenever a signaling operand is present. Three controls alter the classification and the result: the sense of the signaling bit, a switch that makes every NaN quiet, and a default-NaN mode.

Operands and controls are sampled on a clock edge where `in_valid` is high. The result appears on the next cycle together with `out_valid`. The invalid indication is sticky until `flag_clr` is pulsed. A two-state controller tracks the output. In state IDLE nothing new has been delivered. In state EMIT a result captured on the previous edge is on the output. The transitions are as follows. IDLE goes to EMIT when `in_valid` is high. EMIT stays in EMIT while `in_valid` stays high. EMIT returns to IDLE when `in_valid` is low.

Top module: `nanprop_unit`

## Requirements
- R1: An operand is a NaN when bits 30:23 are all ones and bits 22:0 are not all zero. With `snan_one`=0, a NaN with bit 22 clear is signaling and a NaN with bit 22 set is quiet.
- R2: With `snan_one`=1 the sense of bit 22 is swapped. A NaN with bit 22 set is signaling, and a NaN with bit 22 clear is quiet.
- R3: With `no_snan`=1 every NaN is quiet. The invalid flag is not raised by that operation, and the picked operand passes through unmodified.
- R4: A captured operation that has a signaling operand sets `invalid_flag` on the capture edge. The flag stays set until an edge with `flag_clr`=1. On an edge where a clear and a new signaling event coincide, the flag ends set.
- R5: With `dflt_mode`=1 the result is the default NaN regardless of the operands: 0x7FC00000 when `snan_one`=0 and 0x7FBFFFFF when `snan_one`=1. The invalid flag is still raised when a signaling operand is present.
- R6: `policy`=0 picks the first match in this order: A if signaling, then B if signaling, then A if quiet, otherwise B.
- R7: `policy`=1 picks A if A is any NaN, otherwise B.
- R8: `policy`=2 with `use_first`=1 behaves as `policy`=1. With `use_first`=0 it picks B if B is any NaN, otherwise A.
- R9: `policy`=3 handles three cases. A NaN paired with a number yields the NaN. A signaling NaN paired with a quiet NaN yields the quiet one. Two NaNs of the same class yield the one with the larger bits 30:0, and on equal bits 30:0 the one with bit 31 clear.
- R10: A picked signaling operand is quieted. With `snan_one`=0 this means bit 22 is set and all other bits are kept. With `snan_one`=1 the result becomes 0x7FBFFFFF.
- R11: The result and `out_valid`=1 appear on the cycle after the capture edge. After an edge with `in_valid`=0, `out_valid` is 0 and `out_nan` keeps its previous value.
- R12: Reset, active low, clears `out_valid`, `out_nan` and `invalid_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for operands and controls |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| policy | input | 2 | 0 signaling-first, 1 first-NaN, 2 configurable, 3 magnitude tie-break |
| use_first | input | 1 | Direction bit for policy 2 |
| snan_one | input | 1 | 1 swaps the meaning of fraction bit 22 |
| no_snan | input | 1 | 1 treats every NaN as quiet |
| dflt_mode | input | 1 | 1 forces the default NaN as the result |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Result valid, one cycle after capture |
| out_nan | output | 32 | Propagated NaN result |
| invalid_flag | output | 1 | Sticky invalid-operation indication |

## Verification
Under the tie-break policy, the hardest case to reach is two NaNs of the same class whose bits 30:0 are identical, so that the sign alone decides the result. Random NaN draws almost never collide. The stimulus therefore forces a share of its draws to make B a copy of A with the sign inverted, or an exact copy, and adds directed pairs in both sign orders. Signaling operands under inverted polarity with default-NaN mode off are also drawn often. That combination is the only path where quieting replaces the operand entirely.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

    typedef enum logic [1:0] {
        POL_SIGFIRST = 2'd0,
        POL_FIRSTNAN = 2'd1,
        POL_CONFIG   = 2'd2,
        POL_MAGTIE   = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        CLS_NUM    = 2'd0,
        CLS_QUIET  = 2'd1,
        CLS_SIGNAL = 2'd2
    } nan_class_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  snan_one,
    input  logic                  no_snan,
    output nan_class_e            cls
);
    localparam int MSB_POS = FRAC_W - 1;

    logic exp_full;
    logic frac_nz;
    logic msb;

    assign exp_full = &word[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_nz  = |word[FRAC_W-1:0];
    assign msb      = word[MSB_POS];

    always_comb begin
        if (!(exp_full && frac_nz)) begin
            cls = CLS_NUM;
        end else if (no_snan) begin
            cls = CLS_QUIET;
        end else if (msb == snan_one) begin
            cls = CLS_SIGNAL;
        end else begin
            cls = CLS_QUIET;
        end
    end

    // R1 / R2: a word with a clear exponent field is never a NaN
    always_comb begin
        if (!exp_full) begin
            a_r1_num_not_nan: assert (cls == CLS_NUM);
        end
        if (no_snan) begin
            a_r3_no_signal_class: assert (cls != CLS_SIGNAL);
        end
    end

endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
    import nanprop_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  nan_class_e        cls_a,
    input  nan_class_e        cls_b,
    input  policy_e           policy,
    input  logic              use_first,
    output logic              pick_b
);
    logic a_nan, b_nan, a_sig, b_sig, a_q, b_q;
    logic a_bigger;

    assign a_nan = (cls_a != CLS_NUM);
    assign b_nan = (cls_b != CLS_NUM);
    assign a_sig = (cls_a == CLS_SIGNAL);
    assign b_sig = (cls_b == CLS_SIGNAL);
    assign a_q   = (cls_a == CLS_QUIET);
    assign b_q   = (cls_b == CLS_QUIET);

    // magnitude compare; sign-only difference favours the positive word
    always_comb begin
        if (word_a[WORD_W-2:0] > word_b[WORD_W-2:0]) begin
            a_bigger = 1'b1;
        end else if (word_a[WORD_W-2:0] < word_b[WORD_W-2:0]) begin
            a_bigger = 1'b0;
        end else begin
            a_bigger = (word_a < word_b);
        end
    end

    always_comb begin
        pick_b = 1'b0;
        unique case (policy)
            POL_SIGFIRST: begin
                if (a_sig)      pick_b = 1'b0;
                else if (b_sig) pick_b = 1'b1;
                else if (a_q)   pick_b = 1'b0;
                else            pick_b = 1'b1;
            end
            POL_FIRSTNAN: pick_b = !a_nan;
            POL_CONFIG: begin
                if (use_first) pick_b = !a_nan;
                else           pick_b = b_nan;
            end
            POL_MAGTIE: begin
                if (a_sig) begin
                    if (b_sig)    pick_b = !a_bigger;
                    else if (b_q) pick_b = 1'b1;
                    else          pick_b = 1'b0;
                end else if (a_q) begin
                    if (b_q)      pick_b = !a_bigger;
                    else          pick_b = 1'b0;
                end else begin
                    pick_b = 1'b1;
                end
            end
        endcase
    end

    // R9 / R6: when exactly one operand is a NaN, every policy picks it
    always_comb begin
        if (a_nan && !b_nan) begin
            a_r9_lone_nan_a: assert (!pick_b);
        end
        if (b_nan && !a_nan) begin
            a_r9_lone_nan_b: assert (pick_b);
        end
    end

endmodule

// File: rtl/nanprop_quiet.sv
module nanprop_quiet #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] word,
    input  logic                  is_sig,
    input  logic                  snan_one,
    input  logic                  dflt_mode,
    output logic [EXP_W+FRAC_W:0] result
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] DN_NORMAL =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] DN_INVERT =
        {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] QBIT =
        {{(WORD_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] dflt;

    assign dflt = snan_one ? DN_INVERT : DN_NORMAL;

    always_comb begin
        if (dflt_mode) begin
            result = dflt;
        end else if (is_sig) begin
            result = snan_one ? dflt : (word | QBIT);
        end else begin
            result = word;
        end
    end

    // R10: a quieted result always keeps a full exponent field
    always_comb begin
        if (is_sig) begin
            a_r10_exp_full: assert (&result[WORD_W-2:FRAC_W]);
        end
    end

endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [EXP_W+FRAC_W:0]       op_a,
    input  logic [EXP_W+FRAC_W:0]       op_b,
    input  logic [1:0]                  policy,
    input  logic                        use_first,
    input  logic                        snan_one,
    input  logic                        no_snan,
    input  logic                        dflt_mode,
    input  logic                        flag_clr,
    output logic                        out_valid,
    output logic [EXP_W+FRAC_W:0]       out_nan,
    output logic                        invalid_flag
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPS  = 2;
    localparam logic [WORD_W-1:0] DN_NORMAL =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] ops [N_OPS];
    nan_class_e        cls [N_OPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        nanprop_classify #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) u_cls (
            .word    (ops[i]),
            .snan_one(snan_one),
            .no_snan (no_snan),
            .cls     (cls[i])
        );
    end

    logic              pick_b;
    logic [WORD_W-1:0] chosen;
    logic              chosen_sig;
    logic [WORD_W-1:0] res_d;
    logic              inv_d;

    nanprop_pick #(
        .WORD_W(WORD_W)
    ) u_pick (
        .word_a   (op_a),
        .word_b   (op_b),
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .policy   (policy_e'(policy)),
        .use_first(use_first),
        .pick_b   (pick_b)
    );

    assign chosen     = pick_b ? op_b : op_a;
    assign chosen_sig = pick_b ? (cls[1] == CLS_SIGNAL) : (cls[0] == CLS_SIGNAL);
    assign inv_d      = (cls[0] == CLS_SIGNAL) || (cls[1] == CLS_SIGNAL);

    nanprop_quiet #(
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W)
    ) u_quiet (
        .word     (chosen),
        .is_sig   (chosen_sig),
        .snan_one (snan_one),
        .dflt_mode(dflt_mode),
        .result   (res_d)
    );

    // control state machine
    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (in_valid)  state_d = S_EMIT;
            S_EMIT: if (!in_valid) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == S_EMIT);

    // output registers
    logic [WORD_W-1:0] nan_q;
    logic              flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nan_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (in_valid) nan_q <= res_d;
            flag_q <= (flag_q && !flag_clr) || (in_valid && inv_d);
        end
    end

    assign out_nan      = nan_q;
    assign invalid_flag = flag_q;

    // R11: valid timing and result hold
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_nan));
    // R4: sticky flag
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (invalid_flag && !flag_clr) |=> invalid_flag);
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !in_valid) |=> !invalid_flag);
    // R3: no signaling means no new invalid
    a_r3_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && no_snan && (flag_clr || !invalid_flag)) |=> !invalid_flag);
    // R5: default mode, normal polarity
    a_r5_default: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_mode && !snan_one) |=> (out_nan == DN_NORMAL));
    // R10: normal polarity output is quiet whenever some operand was a NaN
    a_r10_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !snan_one && !no_snan &&
         ((cls[0] != CLS_NUM) || (cls[1] != CLS_NUM)))
        |=> (out_nan[FRAC_W-1] && (&out_nan[WORD_W-2:FRAC_W])));

endmodule

// File: tb/nanprop_unit_bench.sv
`timescale 1ns/1ps
module nanprop_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [1:0]  policy = '0;
    logic        use_first = 1'b0, snan_one = 1'b0, no_snan = 1'b0;
    logic        dflt_mode = 1'b0, flag_clr = 1'b0;
    logic        out_valid;
    logic [31:0] out_nan;
    logic        invalid_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    nanprop_unit u_nanprop_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .policy(policy), .use_first(use_first),
        .snan_one(snan_one), .no_snan(no_snan), .dflt_mode(dflt_mode),
        .flag_clr(flag_clr), .out_valid(out_valid), .out_nan(out_nan),
        .invalid_flag(invalid_flag)
    );

    function automatic logic [32:0] ref_out(logic [31:0] a, logic [31:0] b,
        logic [1:0] pol, logic uf, logic inv, logic nos, logic dm);
        logic an, bn, asg, bsg, alarger, pb, ssg;
        logic [31:0] dn, sel, r;
        an  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        bn  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        asg = an && !nos && (a[22] == inv);
        bsg = bn && !nos && (b[22] == inv);
        if (a[30:0] != b[30:0]) alarger = (a[30:0] > b[30:0]);
        else                    alarger = (!a[31] && b[31]);
        case (pol)
            2'd0: pb = asg ? 1'b0 : (bsg ? 1'b1 : !an);
            2'd1: pb = !an;
            2'd2: pb = uf ? !an : bn;
            default: begin
                if (!an)            pb = 1'b1;
                else if (!bn)       pb = 1'b0;
                else if (asg != bsg) pb = asg;
                else                pb = !alarger;
            end
        endcase
        dn  = inv ? 32'h7FBFFFFF : 32'h7FC00000;
        sel = pb ? b : a;
        ssg = pb ? bsg : asg;
        if (dm)       r = dn;
        else if (ssg) r = inv ? dn : (sel | 32'h00400000);
        else          r = sel;
        return {asg | bsg, r};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one operation; clear pulsed with it so the flag reflects this op (R4)
    task automatic run_op(string req, logic [31:0] a, logic [31:0] b,
        logic [1:0] pol, logic uf, logic inv, logic nos, logic dm);
        logic [32:0] e;
        e = ref_out(a, b, pol, uf, inv, nos, dm);
        @(negedge clk);
        op_a = a; op_b = b; policy = pol; use_first = uf;
        snan_one = inv; no_snan = nos; dflt_mode = dm;
        in_valid = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
        check({req, " R11 valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " data"}, out_nan, e[31:0]);
        check({req, " R4 flag"}, {31'd0, invalid_flag}, {31'd0, e[32]});
    endtask

    function automatic logic [31:0] rnd_nan(logic msb);
        logic [31:0] w;
        w = $urandom;
        w[30:23] = 8'hFF;
        w[22] = msb;
        if (w[22:0] == 0) w[0] = 1'b1;
        return w;
    endfunction

    function automatic logic [31:0] rnd_num();
        logic [31:0] w;
        w = $urandom;
        if (w[30:23] == 8'hFF) w[30] = 1'b0;
        return w;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'h1234));
        #1;
        check("R12 reset valid", {31'd0, out_valid}, 32'd0);
        check("R12 reset data", out_nan, 32'd0);
        check("R12 reset flag", {31'd0, invalid_flag}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        run_op("R6 R10 sigfirst b signaling", 32'h7FC00005, 32'h7F800003, 2'd0, 0, 0, 0, 0);
        check("R10 quieted value", out_nan, 32'h7FC00003);
        run_op("R1 quiet a", 32'h7FC00001, 32'h3F800000, 2'd0, 0, 0, 0, 0);
        check("R1 no invalid for quiet", {31'd0, invalid_flag}, 32'd0);
        run_op("R2 R10 inverted quiet to default", 32'h7FC00000, 32'h7F800001, 2'd0, 0, 1, 0, 0);
        check("R2 inverted default", out_nan, 32'h7FBFFFFF);
        run_op("R3 no signaling", 32'h7F800001, 32'h7FC00000, 2'd0, 0, 0, 1, 0);
        check("R3 passthrough", out_nan, 32'h7F800001);
        run_op("R5 default mode", 32'h7F800001, 32'hFFC00000, 2'd3, 0, 0, 0, 1);
        check("R5 default value", out_nan, 32'h7FC00000);
        check("R5 invalid kept", {31'd0, invalid_flag}, 32'd1);
        run_op("R5 default inverted", 32'h12345678, 32'h7FC00000, 2'd1, 0, 1, 0, 1);
        check("R5 default inv value", out_nan, 32'h7FBFFFFF);
        run_op("R7 first nan", 32'h3F800000, 32'hFFC00009, 2'd1, 0, 0, 0, 0);
        run_op("R8 last nan", 32'h7FC00001, 32'h7FC00002, 2'd2, 0, 0, 0, 0);
        check("R8 picks b", out_nan, 32'h7FC00002);
        run_op("R8 use first", 32'h7FC00001, 32'h7FC00002, 2'd2, 1, 0, 0, 0);
        check("R8 picks a", out_nan, 32'h7FC00001);
        run_op("R9 sig vs quiet", 32'h7F800001, 32'hFFC00000, 2'd3, 0, 0, 0, 0);
        check("R9 quiet wins", out_nan, 32'hFFC00000);
        run_op("R9 sign tie b", 32'hFFC00001, 32'h7FC00001, 2'd3, 0, 0, 0, 0);
        check("R9 positive b", out_nan, 32'h7FC00001);
        run_op("R9 sign tie a", 32'h7FC00001, 32'hFFC00001, 2'd3, 0, 0, 0, 0);
        check("R9 positive a", out_nan, 32'h7FC00001);
        run_op("R9 larger", 32'h7FC00001, 32'hFFC00007, 2'd3, 0, 0, 0, 0);
        check("R9 larger mag", out_nan, 32'hFFC00007);

        // R11 hold: idle edge keeps data, drops valid
        held = out_nan;
        @(negedge clk);
        check("R11 idle valid", {31'd0, out_valid}, 32'd0);
        check("R11 hold data", out_nan, held);

        // R4 sticky and clear priority
        run_op("R4 set", 32'h7F800001, 32'h7FC00000, 2'd0, 0, 0, 0, 0);
        @(negedge clk);
        op_a = 32'h7FC00000; op_b = 32'h7FC00000; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 sticky after quiet op", {31'd0, invalid_flag}, 32'd1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R4 cleared", {31'd0, invalid_flag}, 32'd0);

        // constrained random
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] a, b;
            logic [1:0] pol;
            logic uf, inv, nos, dm;
            int kind;
            pol = 2'($urandom_range(0, 3));
            uf  = 1'($urandom);
            inv = 1'($urandom);
            nos = ($urandom_range(0, 7) == 0);
            dm  = ($urandom_range(0, 7) == 0);
            kind = $urandom_range(0, 5);
            a = rnd_nan(1'($urandom));
            b = rnd_nan(1'($urandom));
            case (kind)
                0: a = rnd_num();
                1: b = rnd_num();
                2: b = {~a[31], a[30:0]};
                3: b = a;
                default: ;
            endcase
            run_op("R6 R7 R8 R9 R10 random", a, b, pol, uf, inv, nos, dm);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule